// File: doc/BRIEF.md
# GPIO Pin-Configuration Register Bank

This block is a bank of general-purpose I/O ports, each eight pins wide, behind a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. For every pin, software picks one of four drive modes, sets the value to drive and chooses whether the pad pull-up is on. The block turns these settings into three pad controls per pin: an output enable, an output level and a pull-up enable. The pad input travels through a synchronizer chain into a read-only input register.

A global control word at byte address 0 holds two writable bits. Bit 0 is the bank enable; while it is clear, no pad is driven and the input register is frozen. Bit 1 is a synchronizer-select flag that is stored and read back. The same word reports the bank's port count and a version code. Edge detection and interrupt generation belong to a separate block. The number of ports can be set from one to seven.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the control word's writable bits are 0, and every port's output, mode and pull-up-disable registers are 0. As a result every pad output enable is 0 and every pull-up enable is 1.
- R2: Port p occupies byte addresses p*0x30 onward. Within a port, offset 0x04 is the input register (read-only), 0x08 the output value, 0x0C the mode register and 0x10 the pull-up-disable register. Pin n belongs to port n>>3, bit n&7, and drives pad bit n.
- R3: The mode register holds two bits per pin, at bits 2*(n&7)+1:2*(n&7). The codes are 00 input, 01 push-pull, 10 open-drain and 11 open-source. A pin in input mode never drives its pad.
- R4: In push-pull mode the pad is always driven, and the output level equals the pin's output-value bit.
- R5: In open-drain mode the pad is driven low when the output-value bit is 0 and released when it is 1. The output level is never 1.
- R6: In open-source mode the pad is driven high when the output-value bit is 1 and released when it is 0.
- R7: A 1 in bit n&7 of the pull-up-disable register turns that pin's pull-up enable off, and a 0 turns it on.
- R8: Reading address 0 returns the port count in bits 15:9, the version code in bits 8:2, and the two writable bits in 1:0. Bit 0 is the bank enable and bit 1 the synchronizer-select flag. All other bits read 0.
- R9: While the bank enable is 0, every pad output enable is 0 and the input register holds its value. Writing 0 to address 0 turns the bank off.
- R10: A change on a pad input appears in the input register on the third rising clock edge after it is applied: two synchronizer stages, then the register. Writes to the input register are ignored.
- R11: Unused register bits read 0. These are output-value bits 31:8, mode bits 31:16 and pull-up bits 31:8. Any unassigned offset inside a port, including offset 0 of ports above 0, also reads 0.
- R12: Addresses of ports at or above the configured port count read 0, and writes to them change no register.
- R13: The output level is 0 whenever the pad is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr_en | input | 1 | Write strobe, acts on the rising edge |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 8*NUM_PORTS | Raw pad input levels |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |
| pad_out | output | 8*NUM_PORTS | Pad output levels |
| pad_pu_en | output | 8*NUM_PORTS | Pad pull-up enables |

## Verification
The bench builds the bank with three ports and version code 0x15. Three ports are enough to check the port-count field and the pin-to-pad mapping across more than one port. They also leave ports 3 to 6 of the address space unbacked, so out-of-range reads and ignored writes can be tested. The default synchronizer depth of two is kept, so the bench can check the exact three-edge input latency. One port carries all four drive modes at once, and the bench checks it against several output-value patterns.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned MAX_PORTS     = 7;
   localparam int unsigned PORT_PINS     = 8;
   localparam int unsigned PORT_STRIDE   = 'h30;
   localparam int unsigned PORT_OFF_W    = 6;
   localparam int unsigned MODE_W        = 2;
   localparam int unsigned CFG_W         = PORT_PINS * MODE_W;
   localparam int unsigned BUS_W         = 32;

   localparam logic [PORT_OFF_W-1:0] OFF_DIN  = 6'h04;
   localparam logic [PORT_OFF_W-1:0] OFF_DOUT = 6'h08;
   localparam logic [PORT_OFF_W-1:0] OFF_CFG  = 6'h0C;
   localparam logic [PORT_OFF_W-1:0] OFF_PULL = 6'h10;

   typedef enum logic [MODE_W-1:0] {
      DM_INPUT       = 2'b00,
      DM_PUSH_PULL   = 2'b01,
      DM_OPEN_DRAIN  = 2'b10,
      DM_OPEN_SOURCE = 2'b11
   } drive_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
   import gpio_bank_pkg::*;
(
   input  logic        enable,
   input  drive_mode_e mode,
   input  logic        dout,
   output logic        oe,
   output logic        lvl
);

   always_comb begin
      oe  = 1'b0;
      lvl = 1'b0;
      if (enable) begin
         unique case (mode)
            DM_INPUT: begin
               oe  = 1'b0;
               lvl = 1'b0;
            end
            DM_PUSH_PULL: begin
               oe  = 1'b1;
               lvl = dout;
            end
            DM_OPEN_DRAIN: begin
               oe  = ~dout;
               lvl = 1'b0;
            end
            DM_OPEN_SOURCE: begin
               oe  = dout;
               lvl = dout;
            end
            default: begin
               oe  = 1'b0;
               lvl = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  sel,
   input  logic                  wr_en,
   input  logic [PORT_OFF_W-1:0] offset,
   input  logic [BUS_W-1:0]      wr_data,
   output logic [BUS_W-1:0]      rd_data,
   input  logic [PORT_PINS-1:0]  pad_in,
   output logic [PORT_PINS-1:0]  pad_oe,
   output logic [PORT_PINS-1:0]  pad_out,
   output logic [PORT_PINS-1:0]  pad_pu_en
);

   logic [PORT_PINS-1:0] dout_q;
   logic [PORT_PINS-1:0] pull_dis_q;
   logic [PORT_PINS-1:0] din_q;
   logic [CFG_W-1:0]     cfg_q;
   logic [PORT_PINS-1:0] sync_q;

   gpio_in_sync #(
      .WIDTH  (PORT_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_in),
      .q_o   (sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q     <= '0;
         pull_dis_q <= '0;
         din_q      <= '0;
         cfg_q      <= '0;
      end else begin
         if (enable) din_q <= sync_q;
         if (sel && wr_en) begin
            unique case (offset)
               OFF_DOUT: dout_q     <= wr_data[PORT_PINS-1:0];
               OFF_CFG:  cfg_q      <= wr_data[CFG_W-1:0];
               OFF_PULL: pull_dis_q <= wr_data[PORT_PINS-1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (sel) begin
         unique case (offset)
            OFF_DIN:  rd_data[PORT_PINS-1:0] = din_q;
            OFF_DOUT: rd_data[PORT_PINS-1:0] = dout_q;
            OFF_CFG:  rd_data[CFG_W-1:0]     = cfg_q;
            OFF_PULL: rd_data[PORT_PINS-1:0] = pull_dis_q;
            default:  rd_data = '0;
         endcase
      end
   end

   assign pad_pu_en = ~pull_dis_q;

   generate
      for (genvar i = 0; i < int'(PORT_PINS); i++) begin : g_pin
         drive_mode_e pin_mode;
         assign pin_mode = drive_mode_e'(cfg_q[MODE_W*i +: MODE_W]);

         gpio_pin_drive u_drv (
            .enable (enable),
            .mode   (pin_mode),
            .dout   (dout_q[i]),
            .oe     (pad_oe[i]),
            .lvl    (pad_out[i])
         );

         a_r3_input_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_mode == DM_INPUT) |-> !pad_oe[i]);
         a_r4_push_pull_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && pin_mode == DM_PUSH_PULL) |-> (pad_oe[i] && pad_out[i] == dout_q[i]));
         a_r5_open_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && pin_mode == DM_OPEN_DRAIN) |-> (pad_oe[i] == !dout_q[i] && !pad_out[i]));
         a_r6_open_source_high_only: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && pin_mode == DM_OPEN_SOURCE) |-> (pad_oe[i] == dout_q[i] && pad_out[i] == dout_q[i]));
         a_r9_disabled_releases: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |-> !pad_oe[i]);
         a_r13_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[i] |-> !pad_out[i]);
      end
   endgenerate

   a_r9_input_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> $stable(din_q));
   a_r10_input_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $past(enable) |-> (din_q == $past(sync_q)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 7,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  VERSION_ID  = 7'h0B,
   localparam int unsigned NPINS      = NUM_PORTS * PORT_PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [BUS_W-1:0]  bus_wr_data,
   output logic [BUS_W-1:0]  bus_rd_data,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_pu_en
);

   localparam int unsigned SPAN = NUM_PORTS * PORT_STRIDE;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
         $error("gpio_bank_regs: NUM_PORTS must be 1..7");
      end
      if ((64'd1 << ADDR_W) < 64'(MAX_PORTS * PORT_STRIDE)) begin : g_bad_addr
         $error("gpio_bank_regs: ADDR_W too narrow for the port map");
      end
   endgenerate

   logic [1:0]       ctrl_q;
   logic             bank_en;
   logic             ctrl_hit;
   logic [BUS_W-1:0] ctrl_rd;
   logic [BUS_W-1:0] port_rd [NUM_PORTS];
   logic [BUS_W-1:0] rd_or;

   assign ctrl_hit = (bus_addr == '0);
   assign bank_en  = ctrl_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ctrl_q <= '0;
      else if (ctrl_hit && bus_wr_en) ctrl_q <= bus_wr_data[1:0];
   end

   assign ctrl_rd = {16'h0000, 7'(NUM_PORTS), VERSION_ID, ctrl_q};

   generate
      for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
         localparam logic [ADDR_W-1:0] BASE = ADDR_W'(p * PORT_STRIDE);
         localparam logic [ADDR_W-1:0] TOP  = ADDR_W'((p + 1) * PORT_STRIDE);
         logic              hit;
         logic [ADDR_W-1:0] rel;

         assign hit = (bus_addr >= BASE) && (bus_addr < TOP);
         assign rel = bus_addr - BASE;

         gpio_port_regs #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (bank_en),
            .sel       (hit),
            .wr_en     (bus_wr_en),
            .offset    (rel[PORT_OFF_W-1:0]),
            .wr_data   (bus_wr_data),
            .rd_data   (port_rd[p]),
            .pad_in    (pad_in[p*PORT_PINS +: PORT_PINS]),
            .pad_oe    (pad_oe[p*PORT_PINS +: PORT_PINS]),
            .pad_out   (pad_out[p*PORT_PINS +: PORT_PINS]),
            .pad_pu_en (pad_pu_en[p*PORT_PINS +: PORT_PINS])
         );
      end
   endgenerate

   always_comb begin
      rd_or = '0;
      for (int p = 0; p < int'(NUM_PORTS); p++) rd_or = rd_or | port_rd[p];
   end

   assign bus_rd_data = ctrl_hit ? ctrl_rd : rd_or;

   a_r8_ctrl_identity: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |-> (bus_rd_data[15:9] == 7'(NUM_PORTS) && bus_rd_data[8:2] == VERSION_ID
                    && bus_rd_data[31:16] == 16'h0));
   a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && bus_wr_en) |=> (bus_rd_data[1:0] == $past(bus_wr_data[1:0])) || !ctrl_hit);
   a_r12_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(bus_addr) >= SPAN) |-> (bus_rd_data == '0));
   a_r9_disabled_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en |-> (pad_oe == '0));

endmodule

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;

   localparam int unsigned NP    = 3;
   localparam int unsigned NPIN  = NP * 8;
   localparam logic [6:0]  VER   = 7'h15;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [9:0]      bus_addr = '0;
   logic            bus_wr_en = 1'b0;
   logic [31:0]     bus_wr_data = '0;
   logic [31:0]     bus_rd_data;
   logic [NPIN-1:0] pad_in = '0;
   logic [NPIN-1:0] pad_oe;
   logic [NPIN-1:0] pad_out;
   logic [NPIN-1:0] pad_pu_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   gpio_bank_regs #(
      .NUM_PORTS   (NP),
      .ADDR_W      (10),
      .SYNC_STAGES (2),
      .VERSION_ID  (VER)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr_en   (bus_wr_en),
      .bus_wr_data (bus_wr_data),
      .bus_rd_data (bus_rd_data),
      .pad_in      (pad_in),
      .pad_oe      (pad_oe),
      .pad_out     (pad_out),
      .pad_pu_en   (pad_pu_en)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr    = a;
      bus_wr_data = d;
      bus_wr_en   = 1'b1;
      @(negedge clk);
      bus_wr_en   = 1'b0;
   endtask

   task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rd_data;
   endtask

   // Model of one port from R3..R6, R13: returns {oe, out}
   function automatic logic [15:0] drive_model(input logic [15:0] cfg, input logic [7:0] d);
      logic [7:0] oe, lv;
      for (int i = 0; i < 8; i++) begin
         case (cfg[2*i +: 2])
            2'b01:   begin oe[i] = 1'b1;  lv[i] = d[i]; end
            2'b10:   begin oe[i] = ~d[i]; lv[i] = 1'b0; end
            2'b11:   begin oe[i] = d[i];  lv[i] = d[i]; end
            default: begin oe[i] = 1'b0;  lv[i] = 1'b0; end
         endcase
      end
      return {oe, lv};
   endfunction

   task automatic t_reset;
      logic [31:0] r;
      bus_read(10'h000, r); chk("R1/R8 ctrl after reset", r, 32'h0000_0654);
      chk("R1 oe after reset", 32'(pad_oe), 32'h0);
      chk("R1 pull-up after reset", 32'(pad_pu_en), 32'h00FF_FFFF);
      bus_read(10'h03C, r); chk("R1 mode reg port1 after reset", r, 32'h0);
      bus_read(10'h068, r); chk("R1 dout port2 after reset", r, 32'h0);
   endtask

   task automatic t_ctrl;
      logic [31:0] r;
      bus_write(10'h000, 32'hFFFF_FFFF);
      bus_read(10'h000, r); chk("R8 ctrl write all ones", r, 32'h0000_0657);
      bus_write(10'h000, 32'h0000_0001);
      bus_read(10'h000, r); chk("R8 ctrl enable only", r, 32'h0000_0655);
   endtask

   task automatic t_push_pull;
      logic [31:0] r;
      bus_write(10'h038, 32'hFFFF_FFA5);
      bus_read(10'h038, r); chk("R11 dout upper bits", r, 32'h0000_00A5);
      bus_write(10'h03C, 32'hFFFF_5555);
      bus_read(10'h03C, r); chk("R11 mode upper bits", r, 32'h0000_5555);
      chk("R4 push-pull oe port1", 32'(pad_oe[15:8]), 32'hFF);
      chk("R4 push-pull level port1", 32'(pad_out[15:8]), 32'hA5);
      chk("R2 port0 untouched", 32'(pad_oe[7:0]), 32'h0);
   endtask

   task automatic t_mixed_modes;
      logic [15:0] cfg = 16'h1CE4;
      logic [7:0]  pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
      bus_write(10'h00C, 32'(cfg));
      foreach (pats[k]) begin
         logic [15:0] e;
         bus_write(10'h008, 32'(pats[k]));
         e = drive_model(cfg, pats[k]);
         chk("R3/R5/R6 mixed oe", 32'(pad_oe[7:0]), 32'(e[15:8]));
         chk("R4/R13 mixed level", 32'(pad_out[7:0]), 32'(e[7:0]));
      end
   endtask

   task automatic t_pin_map;
      bus_write(10'h06C, 32'h0000_0040);  // pin 19 push-pull -> port2 bit3
      bus_write(10'h068, 32'h0000_0008);
      chk("R2 pin19 oe", 32'(pad_oe[23:16]), 32'h08);
      chk("R2 pin19 level", 32'(pad_out[23:16]), 32'h08);
   endtask

   task automatic t_pull;
      logic [31:0] r;
      bus_write(10'h070, 32'hFFFF_FF0F);
      bus_read(10'h070, r); chk("R11 pull upper bits", r, 32'h0000_000F);
      chk("R7 pull-up port2", 32'(pad_pu_en[23:16]), 32'hF0);
      chk("R7 pull-up port0 unchanged", 32'(pad_pu_en[7:0]), 32'hFF);
   endtask

   task automatic t_input;
      logic [31:0] r;
      @(negedge clk);
      pad_in[7:0] = 8'h3C;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_read(10'h004, r); chk("R10 not yet after two edges", r, 32'h0);
      @(posedge clk); @(negedge clk);
      bus_read(10'h004, r); chk("R10 captured on third edge", r, 32'h3C);
      bus_write(10'h004, 32'hFFFF_FFFF);
      bus_read(10'h004, r); chk("R10 input write ignored", r, 32'h3C);
   endtask

   task automatic t_gate;
      logic [31:0] r;
      bus_write(10'h000, 32'h0);
      chk("R9 disabled oe", 32'(pad_oe), 32'h0);
      pad_in[7:0] = 8'hC3;
      repeat (5) @(posedge clk);
      @(negedge clk);
      bus_read(10'h004, r); chk("R9 input frozen", r, 32'h3C);
      bus_write(10'h000, 32'h1);
      @(posedge clk); @(negedge clk);
      bus_read(10'h004, r); chk("R9 input resumes", r, 32'hC3);
      chk("R4 drive resumes port1", 32'(pad_oe[15:8]), 32'hFF);
   endtask

   task automatic t_unused;
      logic [31:0] r;
      bus_read(10'h030, r); chk("R11 port1 offset0", r, 32'h0);
      bus_read(10'h014, r); chk("R11 offset 0x14", r, 32'h0);
      bus_read(10'h02C, r); chk("R11 offset 0x2C", r, 32'h0);
   endtask

   task automatic t_out_of_range;
      logic [31:0] r;
      bus_write(10'h098, 32'hFFFF_FFFF);
      bus_write(10'h09C, 32'hFFFF_FFFF);
      bus_write(10'h128, 32'hFFFF_FFFF);
      bus_read(10'h098, r); chk("R12 port3 dout", r, 32'h0);
      bus_read(10'h128, r); chk("R12 port6 dout", r, 32'h0);
      bus_read(10'h038, r); chk("R12 port1 dout intact", r, 32'hA5);
      bus_read(10'h068, r); chk("R12 port2 dout intact", r, 32'h08);
      chk("R12 pads intact", 32'(pad_oe[23:16]), 32'h08);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_push_pull();
      t_mixed_modes();
      t_pin_map();
      t_pull();
      t_input();
      t_gate();
      t_unused();
      t_out_of_range();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule